// File: doc/BRIEF.md
# Consecutive-Cycle Digital Lock Detector

This block watches the up and down pulses of a phase-frequency detector with a fast sample clock. For each comparison cycle it counts how many sample ticks the detector spends with either pulse active. That count is the cycle's phase error. A strobe marks the end of each comparison cycle, and at the strobe the block grades the error against two programmable thresholds given in sample ticks: a low threshold for a small error and a higher one for a large error.

While unlocked, the block counts small-error cycles in an unbroken run. It raises an active-high lock flag once the run reaches three cycles, or five cycles when the precision select is high. After lock, only a cycle whose error is above the higher threshold drops the flag. Errors between the two thresholds are tolerated, and this gap gives hysteresis. With a 1 GHz equivalent sample rate, the usual settings are 15 ticks for the lower threshold and 25 ticks for the higher one. A synchronous reset clears the detector, for example when the loop is powered down or its counters are reset.

Top module: `pfd_lock_detect`

## Requirements
- R1: While `rst` is high on a clock edge, the detector clears: `lock_o` is low from the next cycle, and the good-cycle run restarts from zero.
- R2: A cycle's error is the number of sample ticks, up to and including the strobe tick, on which `up_i` or `dn_i` is high. Counting restarts at zero on the tick after each strobe.
- R3: A cycle is good when its error is strictly less than `set_ticks_i`. An error equal to `set_ticks_i` is not good.
- R4: With `prec_five_i` low, `lock_o` rises after the third consecutive good cycle and not before.
- R5: With `prec_five_i` high, `lock_o` rises after the fifth consecutive good cycle and not before.
- R6: While unlocked, any cycle that is not good resets the consecutive-good count to zero.
- R7: While locked, a single cycle whose error is strictly greater than `clr_ticks_i` drops `lock_o`.
- R8: While locked, a cycle whose error is at most `clr_ticks_i` leaves `lock_o` high. This includes errors between the two thresholds and errors equal to `clr_ticks_i`.
- R9: `lock_o` changes only on the clock edge that samples `cyc_strobe_i` high, and it shows the new value from the following cycle.
- R10: The error count saturates at its all-ones value (255 ticks at default width) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high clear |
| up_i | input | 1 | Detector up pulse |
| dn_i | input | 1 | Detector down pulse |
| cyc_strobe_i | input | 1 | Last tick of a comparison cycle |
| prec_five_i | input | 1 | 0: three good cycles needed, 1: five |
| set_ticks_i | input | TICK_W | Small-error threshold in ticks |
| clr_ticks_i | input | TICK_W | Large-error threshold in ticks |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The bench builds the block with its defaults: an 8-bit tick count and run lengths of 3 and 5. With an 8-bit count, a pulse a few hundred ticks long reaches the saturation ceiling at modest cost. Because the thresholds are inputs, the bench can switch between the nominal 15/25 pair and much tighter pairs during the run. The tighter pairs make equality cases at both thresholds, gaps between them and run breaks occur often under random pulse widths. Directed cases cover a pulse that lasts through the strobe tick, down-only pulses, a precision change and reset while locked.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    // Grade of one finished comparison cycle
    typedef struct packed {
        logic good;   // error below the small-error threshold
        logic bad;    // error above the large-error threshold
    } verdict_t;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

    // Run length needed to declare lock for a given precision select
    function automatic int unsigned run_needed(input logic five,
                                               input int unsigned lo,
                                               input int unsigned hi);
        return five ? hi : lo;
    endfunction

endpackage

// File: rtl/lkd_err_meter.sv
module lkd_err_meter #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_i,
    input  logic              dn_i,
    input  logic              strobe_i,
    output logic [TICK_W-1:0] err_o,
    output logic              err_vld_o
);
    localparam logic [TICK_W-1:0] MAX_CNT = {TICK_W{1'b1}};

    logic [TICK_W-1:0] acc_q;
    logic [TICK_W-1:0] acc_next;
    logic              active;

    assign active   = up_i | dn_i;
    assign acc_next = (active && (acc_q != MAX_CNT)) ? acc_q + 1'b1 : acc_q;

    always_ff @(posedge clk) begin
        if (rst)           acc_q <= '0;
        else if (strobe_i) acc_q <= '0;
        else               acc_q <= acc_next;
    end

    // The strobe tick itself is part of the cycle being graded
    assign err_o     = acc_next;
    assign err_vld_o = strobe_i;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(active && !strobe_i) && ($past(acc_q) != MAX_CNT))
        |-> (acc_q == TICK_W'($past(acc_q) + 1)));

    assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
        $past(strobe_i) |-> (acc_q == '0));

    assert_saturate_R10: assert property (@(posedge clk) disable iff (rst)
        (($past(acc_q) == MAX_CNT) && !$past(strobe_i)) |-> (acc_q == MAX_CNT));

endmodule

// File: rtl/lkd_classify.sv
module lkd_classify
    import lkd_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic [TICK_W-1:0] err_i,
    input  logic [TICK_W-1:0] set_i,
    input  logic [TICK_W-1:0] clr_i,
    output verdict_t          verdict_o
);
    always_comb begin
        verdict_o.good = (err_i < set_i);
        verdict_o.bad  = (err_i > clr_i);
    end

    // R3: with ordered thresholds a cycle is never both good and bad
    always_comb begin
        if (set_i <= clr_i)
            assert_grade_exclusive_R3: assert (!(verdict_o.good && verdict_o.bad));
    end

endmodule

// File: rtl/lkd_tracker.sv
module lkd_tracker
    import lkd_pkg::*;
#(
    parameter int GOOD_LO = 3,
    parameter int GOOD_HI = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe_i,
    input  verdict_t verdict_i,
    input  logic     prec_five_i,
    output logic     lock_o
);
    localparam int CNT_W = $clog2(GOOD_HI + 1);

    lock_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] cnt_inc;

    assign need    = CNT_W'(run_needed(prec_five_i, GOOD_LO, GOOD_HI));
    assign cnt_inc = cnt_q + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (strobe_i) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (verdict_i.good) begin
                        if (cnt_inc >= need) begin
                            state_d = ST_LOCKED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end else begin
                        cnt_d = '0;
                    end
                end
                ST_LOCKED: begin
                    if (verdict_i.bad) begin
                        state_d = ST_HUNT;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_HUNT;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign lock_o = (state_q == ST_LOCKED);

    assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == ST_HUNT && cnt_q == '0));

    assert_rise_on_good_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> $past(strobe_i && verdict_i.good));

    // covers both run lengths (R5 as well)
    assert_run_length_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> ($past(cnt_q) + 1'b1 >= $past(need)));

    assert_drop_on_bad_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_o) |-> $past(strobe_i && verdict_i.bad));

    assert_hold_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (lock_o && !(strobe_i && verdict_i.bad)) |=> lock_o);

    assert_run_break_R6: assert property (@(posedge clk) disable iff (rst)
        (!lock_o && strobe_i && !verdict_i.good) |=> (cnt_q == '0 && !lock_o));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(GOOD_HI));

endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect
    import lkd_pkg::*;
#(
    parameter int TICK_W  = 8,
    parameter int GOOD_LO = 3,
    parameter int GOOD_HI = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_i,
    input  logic              dn_i,
    input  logic              cyc_strobe_i,
    input  logic              prec_five_i,
    input  logic [TICK_W-1:0] set_ticks_i,
    input  logic [TICK_W-1:0] clr_ticks_i,
    output logic              lock_o
);
    logic [TICK_W-1:0] err;
    logic              err_vld;
    verdict_t          verdict;

    lkd_err_meter #(.TICK_W(TICK_W)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .up_i      (up_i),
        .dn_i      (dn_i),
        .strobe_i  (cyc_strobe_i),
        .err_o     (err),
        .err_vld_o (err_vld)
    );

    lkd_classify #(.TICK_W(TICK_W)) u_classify (
        .err_i     (err),
        .set_i     (set_ticks_i),
        .clr_i     (clr_ticks_i),
        .verdict_o (verdict)
    );

    lkd_tracker #(.GOOD_LO(GOOD_LO), .GOOD_HI(GOOD_HI)) u_tracker (
        .clk         (clk),
        .rst         (rst),
        .strobe_i    (err_vld),
        .verdict_i   (verdict),
        .prec_five_i (prec_five_i),
        .lock_o      (lock_o)
    );

endmodule

// File: tb/pfd_lock_detect_tb_top.sv
`timescale 1ns/1ps
module pfd_lock_detect_tb_top;
    localparam int TICK_W = 8;
    localparam int MAXV   = (1 << TICK_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              up_i = 1'b0, dn_i = 1'b0, cyc_strobe_i = 1'b0;
    logic              prec_five_i = 1'b0;
    logic [TICK_W-1:0] set_ticks_i = 8'd15, clr_ticks_i = 8'd25;
    logic              lock_o;

    int vectors = 0, fails = 0, cyc = 0;
    bit done = 0;
    bit exp_lock = 0;
    int exp_cnt  = 0;

    always #2.5 clk = ~clk;

    pfd_lock_detect #(.TICK_W(TICK_W)) dut_i (
        .clk(clk), .rst(rst), .up_i(up_i), .dn_i(dn_i),
        .cyc_strobe_i(cyc_strobe_i), .prec_five_i(prec_five_i),
        .set_ticks_i(set_ticks_i), .clr_ticks_i(clr_ticks_i), .lock_o(lock_o)
    );

    function automatic int meas(int w);
        return (w > MAXV) ? MAXV : w;
    endfunction

    // Reference model of one graded cycle
    task automatic model_step(int e);
        int need;
        need = prec_five_i ? 5 : 3;
        if (!exp_lock) begin
            if (e < int'(set_ticks_i)) begin
                exp_cnt++;
                if (exp_cnt >= need) begin exp_lock = 1; exp_cnt = 0; end
            end else exp_cnt = 0;
        end else if (e > int'(clr_ticks_i)) begin
            exp_lock = 0; exp_cnt = 0;
        end
    endtask

    task automatic chk(bit got, bit exp, string req);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: lock_o=%0b expected %0b at t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; up_i = 0; dn_i = 0; cyc_strobe_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_lock = 0; exp_cnt = 0;
        chk(lock_o, 1'b0, "R1 reset");
    endtask

    // One comparison cycle: pulse of w ticks, then gap ticks, strobe on last tick
    task automatic run_cycle(int w, int gap, bit use_dn, string req);
        int len;
        len = w + gap;
        if (len < 1) len = 1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == len - 1) chk(lock_o, exp_lock, "R9 hold before strobe");
            up_i = (i < w) && !use_dn;
            dn_i = (i < w) &&  use_dn;
            cyc_strobe_i = (i == len - 1);
        end
        @(negedge clk);
        up_i = 0; dn_i = 0; cyc_strobe_i = 0;
        model_step(meas(w));
        chk(lock_o, exp_lock, req);
    endtask

    initial begin
        int r;
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        do_reset();

        // R4: three-cycle run
        run_cycle(5, 2, 0, "R4 after 1 good");
        run_cycle(5, 2, 0, "R4 after 2 good");
        run_cycle(5, 2, 0, "R4 lock on 3rd good");
        // R8: between thresholds and equal to upper
        run_cycle(20, 2, 0, "R8 mid error holds");
        run_cycle(25, 2, 0, "R8 error equal clr holds");
        // R7: just above upper
        run_cycle(26, 2, 0, "R7 error above clr drops");
        // R3/R6: error equal to set breaks run
        run_cycle(3, 2, 0, "R6 good 1");
        run_cycle(3, 2, 0, "R6 good 2");
        run_cycle(15, 2, 0, "R3 equal set not good");
        run_cycle(3, 2, 0, "R6 run restarted 1");
        run_cycle(3, 2, 0, "R6 run restarted 2");
        run_cycle(14, 3, 0, "R3 err 14 good, lock");
        // R2: down pulses counted
        run_cycle(30, 1, 1, "R2 down pulse drops lock");
        // R2: pulse lasting through strobe tick is counted (15 -> not good)
        run_cycle(4, 1, 1, "R2 good 1");
        run_cycle(4, 1, 0, "R2 good 2");
        run_cycle(15, 0, 0, "R2 strobe tick counted");
        run_cycle(4, 1, 0, "R2 no early lock");
        run_cycle(4, 1, 0, "R2 still hunting");
        run_cycle(4, 1, 0, "R2 lock after fresh run");
        // R5: five-cycle run
        prec_five_i = 1'b1;
        run_cycle(40, 1, 0, "R7 drop before prec test");
        for (int k = 1; k <= 4; k++) run_cycle(2, 1, 0, "R5 no lock before 5th");
        run_cycle(2, 1, 0, "R5 lock on 5th good");
        // R10: saturation; 300 ticks would wrap to 44 without it
        clr_ticks_i = 8'd254;
        run_cycle(300, 2, 0, "R10 saturated error above 254");
        clr_ticks_i = 8'd25;
        prec_five_i = 1'b0;
        // R1: reset while locked
        run_cycle(1, 1, 0, "R4 g1");
        run_cycle(1, 1, 0, "R4 g2");
        run_cycle(1, 1, 0, "R4 g3 lock");
        do_reset();
        run_cycle(1, 1, 0, "R1 run cleared by reset");

        // Random phase
        for (int n = 0; n < 600; n++) begin
            int w;
            if (n % 40 == 0) begin
                r = $urandom_range(0, 2);
                if (r == 0) begin set_ticks_i = 15; clr_ticks_i = 25; end
                else if (r == 1) begin set_ticks_i = 6; clr_ticks_i = 12; end
                else begin set_ticks_i = 2; clr_ticks_i = 3; end
            end
            if (n % 57 == 0) prec_five_i = $urandom_range(0, 1);
            r = $urandom_range(0, 9);
            if (r < 6)       w = $urandom_range(0, int'(set_ticks_i));
            else if (r < 8)  w = $urandom_range(int'(set_ticks_i), int'(clr_ticks_i) + 1);
            else if (r < 9)  w = $urandom_range(int'(clr_ticks_i), 60);
            else             w = $urandom_range(0, 270);
            run_cycle(w, $urandom_range(0, 3), $urandom_range(0, 1), "R3 R6 R7 R8 random");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL R9 watchdog: run still active=1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule